// File: doc/BRIEF.md
# Pin-Multiplexed GPIO Port with Edge Interrupts

This block controls one byte-wide general-purpose I/O port. For every pin it holds a set of configuration bits: output data, direction, pin function, resistor request, edge polarity, interrupt enable and interrupt flag. From these bits it produces the four pad-control signals of each pin: the output value, the output enable, the resistor enable and the resistor polarity. A pin's pad can be driven from the output data bit or from a peripheral output line.

Pad inputs pass through a two-stage synchroniser. The synchronised value is readable on the bus and is always passed to the peripheral input lines, whatever function the pin has. The block compares successive synchronised samples to find the chosen edge on each pin. Each detected edge sets a sticky flag. A pin raises an interrupt request when its flag and its enable bit are both 1, and the port interrupt is the OR of all pin requests.

A parameter mask selects which pins exist. The full port has all eight pins. The reduced port has only pins 6 and 7, and its other bits read as 0 and drive nothing.

Top module: `gpio_port`

## Requirements
- R1: `pad_oe_o[i]` equals the direction bit of pin i (register offset 2): 1 means output, 0 means input.
- R2: `pad_out_o[i]` is the output data bit (offset 1) when the pin's function bit (offset 6) is 0, and is `periph_out_i[i]` when that bit is 1.
- R3: `pull_en_o[i]` is 1 only when the resistor bit (offset 7) is 1 and the pin is an input. While it is 1, `pull_up_o[i]` equals the output data bit (1 pulls up, 0 pulls down). Otherwise `pull_up_o[i]` is 0.
- R4: The input register (offset 0) and `periph_in_o` show the pad value after two rising clock edges, whatever the function bit is. Writes to offset 0 have no effect.
- R5: With edge bit (offset 4) at 0, a low-to-high pad change sets the pin's flag (offset 3). With it at 1, a high-to-low change sets the flag. The flag reads 1 after the third rising edge that follows the pad change, and not before.
- R6: Writing the edge bit while the pad is steady leaves the flag unchanged.
- R7: A write to offset 3 loads the flags with the written byte, so software can set or clear them. If an edge is detected in the same cycle, that pin's flag ends up 1.
- R8: `irq_o` is 1 exactly when some pin has both its flag and its enable bit (offset 5) at 1.
- R9: After reset, every register except the input register reads 0, and `pad_oe_o`, `pull_en_o` and `irq_o` are 0.
- R10: Pins outside `PIN_MASK` read 0 at every offset and drive 0 on every pad-control output and on `periph_in_o`. In the reduced port (mask 8'hC0), only pins 6 and 7 work.
- R11: Reads are combinational on `bus_addr_i`. A write with `bus_we_i` takes effect at the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | 3 | Register offset |
| bus_we_i | input | 1 | Write strobe |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for the addressed register |
| pad_in_i | input | 8 | Raw pad input levels |
| periph_out_i | input | 8 | Peripheral drive values |
| periph_in_o | output | 8 | Synchronised pad levels sent to peripherals |
| pad_out_o | output | 8 | Pad output value |
| pad_oe_o | output | 8 | Pad output enable |
| pull_en_o | output | 8 | Resistor enable |
| pull_up_o | output | 8 | Resistor polarity, 1 selects pull-up |
| irq_o | output | 1 | Port interrupt request |

## Verification
The assertions check on every cycle:
- that the resistor is never enabled on a driven pin, and that the pull-up is only asserted when the resistor is enabled;
- that a flag holds when there is neither an edge nor a write;
- that a detected edge always leaves its flag set, even during a write;
- that the synchroniser output lags the pad by two edges;
- that unused pins stay quiet.

The bench scenarios show the rest. These are the exact cycle in which a flag appears, the choice of polarity, that changing the polarity alone sets no flag, that a same-cycle clear loses to an edge, and that the reduced port works next to the full one.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

  typedef enum logic [2:0] {
    REG_IN   = 3'd0,
    REG_OUT  = 3'd1,
    REG_DIR  = 3'd2,
    REG_FLAG = 3'd3,
    REG_EDGE = 3'd4,
    REG_IE   = 3'd5,
    REG_SEL  = 3'd6,
    REG_REN  = 3'd7
  } gpio_reg_e;

  typedef struct packed {
    logic dout;
    logic dir;
    logic fall;
    logic ie;
    logic sel;
    logic ren;
  } pin_cfg_t;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2,
  parameter logic [W-1:0] MASK = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stage_q[s] <= '0;
        else         stage_q[s] <= d_i & MASK;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stage_q[s] <= '0;
        else         stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];

  // age counter only for the latency check
  logic [1:0] age_q;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)          age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;

  if (STAGES == 2) begin : g_chk
    AST_SYNC_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (age_q >= 2'd2) |-> (q_o == ($past(d_i, 2) & MASK))) // R4
      else $error("sync latency");
  end

endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int W = 8,
  parameter logic [W-1:0] MASK = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  gpio_reg_e    addr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] dout_o,
  output logic [W-1:0] dir_o,
  output logic [W-1:0] fall_o,
  output logic [W-1:0] ie_o,
  output logic [W-1:0] sel_o,
  output logic [W-1:0] ren_o
);

  pin_cfg_t cfg [W];

  for (genvar i = 0; i < W; i++) begin : g_pin
    if (MASK[i]) begin : g_impl
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          cfg[i] <= '0;
        end else if (we_i) begin
          unique case (addr_i)
            REG_OUT:  cfg[i].dout <= wdata_i[i];
            REG_DIR:  cfg[i].dir  <= wdata_i[i];
            REG_EDGE: cfg[i].fall <= wdata_i[i];
            REG_IE:   cfg[i].ie   <= wdata_i[i];
            REG_SEL:  cfg[i].sel  <= wdata_i[i];
            REG_REN:  cfg[i].ren  <= wdata_i[i];
            default: ;
          endcase
        end
      end
    end else begin : g_absent
      assign cfg[i] = '0;
    end
    assign dout_o[i] = cfg[i].dout;
    assign dir_o[i]  = cfg[i].dir;
    assign fall_o[i] = cfg[i].fall;
    assign ie_o[i]   = cfg[i].ie;
    assign sel_o[i]  = cfg[i].sel;
    assign ren_o[i]  = cfg[i].ren;
  end

  AST_CFG_HOLD_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> ($stable(dir_o) && $stable(dout_o) && $stable(ie_o))) // R11
    else $error("cfg changed without write");

endmodule

// File: rtl/gpio_flags.sv
module gpio_flags #(
  parameter int W = 8,
  parameter logic [W-1:0] MASK = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] sample_i,
  input  logic [W-1:0] fall_i,
  input  logic         flag_we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] flag_o
);

  logic [W-1:0] prev_q;
  logic [W-1:0] edge_w;

  for (genvar i = 0; i < W; i++) begin : g_pin
    if (MASK[i]) begin : g_impl
      logic flag_q;
      // compare samples only, so a polarity write alone cannot fire
      assign edge_w[i] = fall_i[i] ? (prev_q[i] & ~sample_i[i])
                                   : (~prev_q[i] & sample_i[i]);
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          prev_q[i] <= 1'b0;
          flag_q    <= 1'b0;
        end else begin
          prev_q[i] <= sample_i[i];
          flag_q    <= (flag_we_i ? wdata_i[i] : flag_q) | edge_w[i];
        end
      end
      assign flag_o[i] = flag_q;
    end else begin : g_absent
      assign prev_q[i] = 1'b0;
      assign edge_w[i] = 1'b0;
      assign flag_o[i] = 1'b0;
    end
  end

  AST_FLAG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flag_we_i && !(|edge_w)) |=> (flag_o == $past(flag_o))) // R6
    else $error("flag moved without cause");

  AST_EDGE_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|edge_w) |=> ((flag_o & $past(edge_w)) == $past(edge_w))) // R7
    else $error("edge lost");

  AST_SW_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_we_i && !(|edge_w)) |=> (flag_o == ($past(wdata_i) & MASK))) // R7
    else $error("flag write not loaded");

endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] dout_i,
  input  logic [W-1:0] dir_i,
  input  logic [W-1:0] sel_i,
  input  logic [W-1:0] ren_i,
  input  logic [W-1:0] periph_out_i,
  output logic [W-1:0] pad_out_o,
  output logic [W-1:0] pad_oe_o,
  output logic [W-1:0] pull_en_o,
  output logic [W-1:0] pull_up_o
);

  for (genvar i = 0; i < W; i++) begin : g_pin
    always_comb begin
      pad_out_o[i] = sel_i[i] ? periph_out_i[i] : dout_i[i];
      pad_oe_o[i]  = dir_i[i];
      pull_en_o[i] = ren_i[i] & ~dir_i[i];
      pull_up_o[i] = pull_en_o[i] & dout_i[i];
    end
  end

  AST_PULL_ONLY_INPUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pull_en_o & pad_oe_o) == '0) // R3
    else $error("pull on driven pin");

  AST_PULLUP_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pull_up_o & ~pull_en_o) == '0) // R3
    else $error("pull-up without enable");

endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_pkg::*;
#(
  parameter int W = 8,
  parameter logic [W-1:0] PIN_MASK = '1,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [2:0]   bus_addr_i,
  input  logic         bus_we_i,
  input  logic [W-1:0] bus_wdata_i,
  output logic [W-1:0] bus_rdata_o,
  input  logic [W-1:0] pad_in_i,
  input  logic [W-1:0] periph_out_i,
  output logic [W-1:0] periph_in_o,
  output logic [W-1:0] pad_out_o,
  output logic [W-1:0] pad_oe_o,
  output logic [W-1:0] pull_en_o,
  output logic [W-1:0] pull_up_o,
  output logic         irq_o
);

  gpio_reg_e    addr;
  logic [W-1:0] sample, dout, dir, fall, ie, sel, ren, flag;
  logic [W-1:0] pad_out_raw;

  assign addr = gpio_reg_e'(bus_addr_i);

  gpio_sync #(.W(W), .STAGES(SYNC_STAGES), .MASK(PIN_MASK)) u_sync (
    .clk_i, .rst_ni, .d_i(pad_in_i), .q_o(sample)
  );

  gpio_regs #(.W(W), .MASK(PIN_MASK)) u_regs (
    .clk_i, .rst_ni,
    .we_i(bus_we_i), .addr_i(addr), .wdata_i(bus_wdata_i),
    .dout_o(dout), .dir_o(dir), .fall_o(fall), .ie_o(ie), .sel_o(sel), .ren_o(ren)
  );

  gpio_flags #(.W(W), .MASK(PIN_MASK)) u_flags (
    .clk_i, .rst_ni,
    .sample_i(sample), .fall_i(fall),
    .flag_we_i(bus_we_i && addr == REG_FLAG), .wdata_i(bus_wdata_i),
    .flag_o(flag)
  );

  gpio_pad_mux #(.W(W)) u_mux (
    .clk_i, .rst_ni,
    .dout_i(dout), .dir_i(dir), .sel_i(sel), .ren_i(ren),
    .periph_out_i(periph_out_i),
    .pad_out_o(pad_out_raw), .pad_oe_o(pad_oe_o),
    .pull_en_o(pull_en_o), .pull_up_o(pull_up_o)
  );

  assign pad_out_o   = pad_out_raw & PIN_MASK;
  assign periph_in_o = sample;
  assign irq_o       = |(flag & ie);

  always_comb begin
    unique case (addr)
      REG_IN:   bus_rdata_o = sample;
      REG_OUT:  bus_rdata_o = dout;
      REG_DIR:  bus_rdata_o = dir;
      REG_FLAG: bus_rdata_o = flag;
      REG_EDGE: bus_rdata_o = fall;
      REG_IE:   bus_rdata_o = ie;
      REG_SEL:  bus_rdata_o = sel;
      REG_REN:  bus_rdata_o = ren;
      default:  bus_rdata_o = '0;
    endcase
  end

  AST_UNIMPL_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pad_out_o | pad_oe_o | pull_en_o | periph_in_o | bus_rdata_o) & ~PIN_MASK) == '0) // R10
    else $error("absent pin active");

  AST_IRQ_AFTER_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && addr == REG_FLAG && bus_wdata_i == '0 && $stable(sample)) |=> !irq_o) // R8
    else $error("irq after full clear");

endmodule

// File: tb/sim_gpio_port.sv
`timescale 1ns/1ps
module sim_gpio_port;

  logic       clk = 0;
  logic       rst_n = 0;
  logic [2:0] addr = 0;
  logic       we = 0;
  logic [7:0] wdata = 0, pad = 0, periph = 0;
  logic [7:0] rdata, pin, pout, poe, pen, pup;
  logic       irq;
  logic [7:0] rdata1, pin1, pout1, poe1, pen1, pup1;
  logic       irq1;

  int n_chk = 0, n_fail = 0;
  localparam logic [7:0] SMALL = 8'hC0;

  always #4 clk = ~clk;

  gpio_port u0 (
    .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_we_i(we), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .pad_in_i(pad), .periph_out_i(periph), .periph_in_o(pin),
    .pad_out_o(pout), .pad_oe_o(poe), .pull_en_o(pen), .pull_up_o(pup), .irq_o(irq)
  );

  gpio_port #(.PIN_MASK(8'hC0)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_we_i(we), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata1), .pad_in_i(pad), .periph_out_i(periph), .periph_in_o(pin1),
    .pad_out_o(pout1), .pad_oe_o(poe1), .pull_en_o(pen1), .pull_up_o(pup1), .irq_o(irq1)
  );

  // reference state
  logic [7:0] m_s1 = 0, m_s2 = 0, m_prev = 0;
  logic [7:0] m_out = 0, m_dir = 0, m_flag = 0, m_fall = 0, m_ie = 0, m_sel = 0, m_ren = 0;

  function automatic logic [7:0] exp_rd(logic [2:0] a);
    case (a)
      3'd0: return m_s2;   3'd1: return m_out;
      3'd2: return m_dir;  3'd3: return m_flag;
      3'd4: return m_fall; 3'd5: return m_ie;
      3'd6: return m_sel;  default: return m_ren;
    endcase
  endfunction

  function automatic logic [7:0] exp_pout();
    return (m_sel & periph) | (~m_sel & m_out);
  endfunction

  function automatic logic [7:0] exp_pen();
    return m_ren & ~m_dir;
  endfunction

  task automatic chk(string req, string what, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic check_all();
    chk("R1", "pad_oe", poe, m_dir);
    chk("R2", "pad_out", pout, exp_pout());
    chk("R3", "pull_en", pen, exp_pen());
    chk("R3", "pull_up", pup, exp_pen() & m_out);
    chk("R4", "periph_in", pin, m_s2);
    chk("R11", "rdata", rdata, exp_rd(addr));
    chk("R8", "irq", {7'd0, irq}, {7'd0, |(m_ie & m_flag)});
    chk("R10", "small rdata", rdata1, exp_rd(addr) & SMALL);
    chk("R10", "small pad_out", pout1, exp_pout() & SMALL);
    chk("R10", "small pad_oe", poe1, m_dir & SMALL);
    chk("R10", "small pull", pen1 | pup1, (exp_pen() | (exp_pen() & m_out)) & SMALL);
    chk("R10", "small periph_in", pin1, m_s2 & SMALL);
    chk("R10", "small irq", {7'd0, irq1}, {7'd0, |(m_ie & m_flag & SMALL)});
  endtask

  task automatic model_step();
    logic [7:0] edg;
    edg = (m_fall & m_prev & ~m_s2) | (~m_fall & ~m_prev & m_s2);
    m_flag = ((we && addr == 3'd3) ? wdata : m_flag) | edg;
    if (we) begin
      case (addr)
        3'd1: m_out = wdata;  3'd2: m_dir = wdata;
        3'd4: m_fall = wdata; 3'd5: m_ie = wdata;
        3'd6: m_sel = wdata;  3'd7: m_ren = wdata;
        default: ;
      endcase
    end
    m_prev = m_s2; m_s2 = m_s1; m_s1 = pad;
  endtask

  // called at negedge: check, advance one clock, return at next negedge
  task automatic tick();
    #1 check_all();
    @(posedge clk);
    model_step();
    @(negedge clk);
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    addr = a; we = 1; wdata = d;
    tick();
    we = 0;
  endtask

  task automatic expect_reg(logic [2:0] a, logic [7:0] exp, string req);
    addr = a; we = 0;
    #1 chk(req, "directed read", rdata, exp);
  endtask

  initial begin
    #(8ns * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R9 reset state
    for (int a = 1; a < 8; a++) expect_reg(3'(a), 8'h00, "R9");
    chk("R9", "oe after reset", poe, 8'h00);
    chk("R9", "pull after reset", pen, 8'h00);
    chk("R9", "irq after reset", {7'd0, irq}, 8'h00);
    tick();

    // R4 input path, offset 0 read-only
    pad = 8'h3C; tick(); tick();
    expect_reg(3'd0, 8'h3C, "R4");
    wr(3'd0, 8'hFF);
    expect_reg(3'd0, 8'h3C, "R4");
    pad = 8'h00; tick(); tick(); tick();
    wr(3'd3, 8'h00);
    tick();

    // R5 rising edge timing
    wr(3'd5, 8'hFF);
    pad = 8'h05; tick(); tick();
    expect_reg(3'd3, 8'h00, "R5");
    tick();
    expect_reg(3'd3, 8'h05, "R5");
    chk("R8", "irq on flag", {7'd0, irq}, 8'h01);
    wr(3'd3, 8'h00);
    chk("R8", "irq cleared", {7'd0, irq}, 8'h00);

    // R6 polarity change on steady pad
    wr(3'd4, 8'hFF); tick(); tick();
    expect_reg(3'd3, 8'h00, "R6");

    // R5 falling edge
    pad = 8'h00; tick(); tick(); tick();
    expect_reg(3'd3, 8'h05, "R5");

    // R7 clear collides with edge
    wr(3'd3, 8'h00); wr(3'd4, 8'h00);
    pad = 8'h80; tick(); tick();
    wr(3'd3, 8'h00);
    expect_reg(3'd3, 8'h80, "R7");
    wr(3'd3, 8'h11);
    expect_reg(3'd3, 8'h11, "R7");
    wr(3'd3, 8'h00);
    expect_reg(3'd3, 8'h00, "R7");

    // R8 enable masking
    wr(3'd5, 8'h00); wr(3'd3, 8'hFF);
    chk("R8", "irq masked", {7'd0, irq}, 8'h00);
    wr(3'd5, 8'h08);
    chk("R8", "irq one pin", {7'd0, irq}, 8'h01);
    addr = 3'd3; #1 chk("R10", "small flags", rdata1, 8'hC0);
    tick();

    // R2/R3 directed mux
    wr(3'd1, 8'hA5); wr(3'd2, 8'h0F); wr(3'd7, 8'hFF); wr(3'd6, 8'h33);
    periph = 8'h5A; #1;
    chk("R2", "directed pad_out", pout, 8'h5A & 8'h33 | 8'hA5 & 8'hCC);
    chk("R3", "directed pull_en", pen, 8'hF0);
    chk("R3", "directed pull_up", pup, 8'hA0);
    tick();

    // random phase
    for (int i = 0; i < 4000; i++) begin
      addr  = 3'($urandom_range(0, 7));
      we    = ($urandom_range(0, 3) == 0);
      wdata = 8'($urandom);
      if ($urandom_range(0, 2) == 0) pad = 8'($urandom);
      periph = 8'($urandom);
      tick();
    end
    we = 0;
    tick();

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule